// File: doc/BRIEF.md
# Byte-Command GPIO Bank Engine

This block turns an inbound byte stream into control of sixteen I/O pins. The pins are grouped as two banks of eight: a low bank holding pins 0 to 7 and a high bank holding pins 8 to 15. Each bank has an output-value register and a direction register. A set command writes both registers of one bank. A get command samples the live levels of one bank and returns them on an outbound byte stream.

Both byte streams use valid/ready handshakes. Each reply packet starts with two fixed status bytes, and the sampled data byte follows them. The pins are presented as three vectors. The drive value leaves on `pinOut` and the per-pin output enable on `pinOe`. External levels arrive on `pinIn`, which passes through a two-flop synchronizer before it is sampled.

Top module: `byte_gpio_engine`

## Requirements
- R1: After reset, `pinOut` and `pinOe` are all zero, which makes every pin an input. After reset `outValid` is low and `inReady` is high.
- R2: Byte 0x80 followed by a value byte and a direction byte writes the low bank: the value byte appears on `pinOut[7:0]`. Byte 0x82 does the same for the high bank on `pinOut[15:8]`. Opcode bit 1 selects the bank. Pin i belongs to bank i[3] at bit i[2:0].
- R3: In the direction byte of a set command, bit k = 1 drives `pinOe` high for that bank's pin k, making it an output. Bit k = 0 drives `pinOe` low, making the pin an input.
- R4: A set command leaves the value and direction of the other bank unchanged.
- R5: Byte 0x81 reads the low bank and 0x83 reads the high bank. Each produces a three-byte reply: 0x32, then 0x60, then the data byte. A byte stays on `outData` with `outValid` high until `outReady` accepts it.
- R6: The reply data byte is the selected bank's `pinIn` levels after a two-flop synchronizer, captured at the edge that accepts the get opcode. A level change presented only one edge before that acceptance does not appear in the reply.
- R7: In the idle state, any byte outside 0x80 to 0x83 is consumed and dropped. It has no effect on the pins, and the next byte is again decoded as an opcode.
- R8: The engine waits indefinitely between the operand bytes of a set command. The pins do not change after the value byte alone. The value and direction of the bank update together at the edge that accepts the direction byte.
- R9: `inReady` is low while a reply is being sent, and high at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Inbound byte valid |
| inData | input | 8 | Inbound command or operand byte |
| inReady | output | 1 | Engine accepts an inbound byte |
| outValid | output | 1 | Outbound reply byte valid |
| outData | output | 8 | Outbound reply byte |
| outReady | input | 1 | Consumer accepts the reply byte |
| pinIn | input | 16 | External pin levels, asynchronous |
| pinOut | output | 16 | Drive values of the pins |
| pinOe | output | 16 | Output enable per pin, 1 = output |

## Verification
The bench goes after the following corner cases:
- A set command stalled between its value and direction bytes. An engine that committed early would move `pinOut` before the direction byte arrives.
- Sets on one bank followed by checks on the other. A bank-select slip would overwrite the wrong half.
- Unknown bytes followed directly by a get opcode. An engine that treated the junk as the start of a command would swallow the get, and no reply would appear.
- A pin change presented together with a get opcode. A design that skipped the synchronizer would return the new level where the old one is expected.
- A reply held by a low `outReady`, alongside random traffic compared each cycle. Dropped, reordered or unstable reply bytes would show up as mismatches.

// File: rtl/byte_gpio_pkg.sv
package byte_gpio_pkg;
  localparam int BYTE_W    = 8;
  localparam int REPLY_LEN = 3;
  localparam int IDX_W     = $clog2(REPLY_LEN);
  localparam logic [5:0] OPC_TOP = 6'b100000;

  typedef struct packed {
    logic loadVal;
    logic commitSet;
    logic captureGet;
    logic bankSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/byte_gpio_ctrl.sv
module byte_gpio_ctrl
  import byte_gpio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [BYTE_W-1:0] inData,
  output logic              inReady,
  output logic              outValid,
  input  logic              outReady,
  output logic [IDX_W-1:0]  replyIdx,
  output logic              parserIdle,
  output ctrlStrobe_t       strobe
);
  typedef enum logic [1:0] {ST_IDLE, ST_VALUE, ST_DIR, ST_REPLY} state_t;

  state_t           stQ, stD;
  logic             bankQ;
  logic [IDX_W-1:0] idxQ;
  logic             fireIn, isOpc, lastByte, popReply;

  assign inReady    = (stQ != ST_REPLY);
  assign outValid   = (stQ == ST_REPLY);
  assign parserIdle = (stQ == ST_IDLE);
  assign fireIn     = inValid && inReady;
  assign isOpc      = (inData[BYTE_W-1:2] == OPC_TOP);
  assign lastByte   = (idxQ == IDX_W'(REPLY_LEN - 1));
  assign replyIdx   = idxQ;

  always_comb begin
    stD            = stQ;
    strobe         = '0;
    strobe.bankSel = bankQ;
    popReply       = 1'b0;
    case (stQ)
      ST_IDLE: begin
        strobe.bankSel = inData[1];
        if (fireIn && isOpc) begin
          if (inData[0]) begin
            strobe.captureGet = 1'b1;
            stD               = ST_REPLY;
          end else begin
            stD = ST_VALUE;
          end
        end
      end
      ST_VALUE: begin
        if (fireIn) begin
          strobe.loadVal = 1'b1;
          stD            = ST_DIR;
        end
      end
      ST_DIR: begin
        if (fireIn) begin
          strobe.commitSet = 1'b1;
          stD              = ST_IDLE;
        end
      end
      default: begin
        if (outReady) begin
          popReply = 1'b1;
          if (lastByte) stD = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ   <= ST_IDLE;
      bankQ <= 1'b0;
      idxQ  <= '0;
    end else begin
      stQ <= stD;
      if (stQ == ST_IDLE && fireIn && isOpc && !inData[0]) bankQ <= inData[1];
      if (strobe.captureGet)  idxQ <= '0;
      else if (popReply)      idxQ <= idxQ + 1'b1;
    end
  end
endmodule

// File: rtl/byte_gpio_dpath.sv
module byte_gpio_dpath
  import byte_gpio_pkg::*;
#(
  parameter int          DATA_W   = BYTE_W,
  parameter logic [7:0]  STATUS_A = 8'h32,
  parameter logic [7:0]  STATUS_B = 8'h60,
  localparam int         BANKS    = 2,
  localparam int         PIN_W    = BANKS * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] inData,
  input  logic [IDX_W-1:0]  replyIdx,
  input  logic [PIN_W-1:0]  pinIn,
  output logic [PIN_W-1:0]  pinOut,
  output logic [PIN_W-1:0]  pinOe,
  output logic [DATA_W-1:0] outData
);
  logic [DATA_W-1:0] holdQ, replyQ;
  logic [PIN_W-1:0]  syncA, syncB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA  <= '0;
      syncB  <= '0;
      holdQ  <= '0;
      replyQ <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
      if (strobe.loadVal) holdQ <= inData;
      if (strobe.captureGet) replyQ <= syncB[(strobe.bankSel ? 1 : 0)*DATA_W +: DATA_W];
    end
  end

  for (genvar g = 0; g < BANKS; g++) begin : gBank
    logic [DATA_W-1:0] valQ, dirQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        valQ <= '0;
        dirQ <= '0;
      end else if (strobe.commitSet && (strobe.bankSel == g[0])) begin
        valQ <= holdQ;
        dirQ <= inData;
      end
    end
    assign pinOut[g*DATA_W +: DATA_W] = valQ;
    assign pinOe[g*DATA_W +: DATA_W]  = dirQ;
  end

  always_comb begin
    case (replyIdx)
      IDX_W'(0): outData = STATUS_A;
      IDX_W'(1): outData = STATUS_B;
      default:   outData = replyQ;
    endcase
  end
endmodule

// File: rtl/byte_gpio_engine.sv
module byte_gpio_engine
  import byte_gpio_pkg::*;
#(
  parameter logic [7:0] STATUS_A = 8'h32,
  parameter logic [7:0] STATUS_B = 8'h60,
  localparam int        PIN_W    = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [BYTE_W-1:0] inData,
  output logic              inReady,
  output logic              outValid,
  output logic [BYTE_W-1:0] outData,
  input  logic              outReady,
  input  logic [PIN_W-1:0]  pinIn,
  output logic [PIN_W-1:0]  pinOut,
  output logic [PIN_W-1:0]  pinOe
);
  ctrlStrobe_t      strobe;
  logic [IDX_W-1:0] replyIdx;
  logic             parserIdle;

  byte_gpio_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .inReady(inReady), .outValid(outValid), .outReady(outReady),
    .replyIdx(replyIdx), .parserIdle(parserIdle), .strobe(strobe)
  );

  byte_gpio_dpath #(.DATA_W(BYTE_W), .STATUS_A(STATUS_A), .STATUS_B(STATUS_B)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inData(inData),
    .replyIdx(replyIdx), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe),
    .outData(outData)
  );
endmodule

// File: rtl/byte_gpio_chk.sv
module byte_gpio_chk #(
  parameter logic [7:0] STATUS_A = 8'h32
) (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [7:0]  inData,
  input logic        inReady,
  input logic        outValid,
  input logic [7:0]  outData,
  input logic        outReady,
  input logic [15:0] pinOut,
  input logic [15:0] pinOe,
  input logic        parserIdle
);
  AST_REPLY_HELD: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData)); // R5

  AST_FIRST_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> outData == STATUS_A); // R5

  AST_GET_STARTS_REPLY: assert property (@(posedge clk) disable iff (!rstN)
    parserIdle && inValid && inReady && inData[7:2] == 6'b100000 && inData[0] |=> outValid); // R5

  AST_READY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady); // R9

  AST_PINS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !(inValid && inReady) |=> $stable(pinOut) && $stable(pinOe)); // R8

  AST_DROP_UNKNOWN: assert property (@(posedge clk) disable iff (!rstN)
    parserIdle && inValid && inReady && inData[7:2] != 6'b100000 |=> parserIdle && $stable(pinOut) && $stable(pinOe)); // R7
endmodule

bind byte_gpio_engine byte_gpio_chk #(.STATUS_A(STATUS_A)) chk_i (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inReady(inReady),
  .outValid(outValid), .outData(outData), .outReady(outReady),
  .pinOut(pinOut), .pinOe(pinOe), .parserIdle(parserIdle)
);

// File: tb/byte_gpio_engine_tb.sv
module byte_gpio_engine_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [7:0]  inData = 8'h00;
  logic        inReady, outValid, outReady = 1'b1;
  logic [7:0]  outData;
  logic [15:0] pinIn = 16'h0000;
  logic [15:0] pinOut, pinOe;

  int checks = 0;
  int errs = 0;
  bit done = 0;
  bit cmpOn = 0;

  always #5 clk = ~clk;

  byte_gpio_engine dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inReady(inReady),
    .outValid(outValid), .outData(outData), .outReady(outReady),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe)
  );

  // behavioural reference
  logic [15:0] mVal, mDir, mS1, mS2;
  logic [7:0]  mHold;
  int          mPhase;
  int          mBank;
  logic [7:0]  rq[$];
  bit          mRdy;

  always @(posedge clk) begin
    if (!rstN) begin
      mVal = 0; mDir = 0; mS1 = 0; mS2 = 0; mHold = 0; mPhase = 0; mBank = 0;
      rq.delete();
    end else begin
      mRdy = (rq.size() == 0);
      if (rq.size() > 0 && outReady) void'(rq.pop_front());
      if (inValid && mRdy) begin
        if (mPhase == 0) begin
          if (inData >= 8'h80 && inData <= 8'h83) begin
            if (inData[0]) begin
              rq.push_back(8'h32);
              rq.push_back(8'h60);
              rq.push_back(inData[1] ? mS2[15:8] : mS2[7:0]);
            end else begin
              mBank  = inData[1] ? 1 : 0;
              mPhase = 1;
            end
          end
        end else if (mPhase == 1) begin
          mHold  = inData;
          mPhase = 2;
        end else begin
          mVal[mBank*8 +: 8] = mHold;
          mDir[mBank*8 +: 8] = inData;
          mPhase = 0;
        end
      end
      mS2 = mS1;
      mS1 = pinIn;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmpOn && rstN) begin
      chk("R9 inReady", 32'(inReady), 32'(rq.size() == 0));
      chk("R5 outValid", 32'(outValid), 32'(rq.size() > 0));
      if (rq.size() > 0) chk("R5 outData", 32'(outData), 32'(rq[0]));
      chk("R2 pinOut", 32'(pinOut), 32'(mVal));
      chk("R3 pinOe", 32'(pinOe), 32'(mDir));
    end
  end

  task automatic sendByte(logic [7:0] b);
    @(negedge clk);
    while (!inReady) @(negedge clk);
    inValid = 1'b1;
    inData  = b;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic collect(string tag, logic [7:0] expData);
    logic [7:0] got[3];
    int n = 0;
    int guard = 0;
    while (n < 3 && guard < 50) begin
      if (outValid && outReady) begin
        got[n] = outData;
        n++;
      end
      guard++;
      @(negedge clk);
    end
    chk({tag, " status0"}, 32'(got[0]), 32'h32);
    chk({tag, " status1"}, 32'(got[1]), 32'h60);
    chk({tag, " data"}, 32'(got[2]), 32'(expData));
  endtask

  task automatic setBank(logic [7:0] op, logic [7:0] v, logic [7:0] d);
    sendByte(op);
    sendByte(v);
    sendByte(d);
  endtask

  initial begin
    #500000;
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 pinOut", 32'(pinOut), 32'h0);
    chk("R1 pinOe", 32'(pinOe), 32'h0);
    chk("R1 outValid", 32'(outValid), 32'h0);
    chk("R1 inReady", 32'(inReady), 32'h1);
    rstN = 1'b1;
    cmpOn = 1'b1;
    @(negedge clk);

    setBank(8'h80, 8'hA5, 8'h0F);
    chk("R2 low value", 32'(pinOut), 32'h00A5);
    chk("R3 low dir", 32'(pinOe), 32'h000F);
    setBank(8'h82, 8'h3C, 8'hF0);
    chk("R4 both banks value", 32'(pinOut), 32'h3CA5);
    chk("R4 both banks dir", 32'(pinOe), 32'hF00F);

    sendByte(8'h80);
    sendByte(8'h11);
    repeat (20) @(negedge clk);
    chk("R8 no early value", 32'(pinOut), 32'h3CA5);
    chk("R8 no early dir", 32'(pinOe), 32'hF00F);
    sendByte(8'hFF);
    chk("R8 value commit", 32'(pinOut), 32'h3C11);
    chk("R8 dir commit", 32'(pinOe), 32'hF0FF);

    pinIn = 16'h1234;
    sendByte(8'h55);
    sendByte(8'h84);
    sendByte(8'h00);
    chk("R7 pins kept", 32'(pinOut), 32'h3C11);
    chk("R7 dir kept", 32'(pinOe), 32'hF0FF);
    chk("R7 ready", 32'(inReady), 32'h1);
    sendByte(8'h83);
    collect("R7 get after junk", 8'h12);

    sendByte(8'h81);
    collect("R6 low read", 8'h34);

    @(negedge clk);
    pinIn   = 16'hBEEF;
    inValid = 1'b1;
    inData  = 8'h81;
    @(negedge clk);
    inValid = 1'b0;
    collect("R6 sync delay", 8'h34);
    sendByte(8'h81);
    collect("R6 new level", 8'hEF);

    outReady = 1'b0;
    sendByte(8'h83);
    repeat (5) @(negedge clk);
    chk("R5 stall valid", 32'(outValid), 32'h1);
    chk("R5 stall byte", 32'(outData), 32'h32);
    chk("R9 stall ready", 32'(inReady), 32'h0);
    outReady = 1'b1;
    collect("R5 stalled reply", 8'hBE);

    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      outReady = ($urandom % 3) != 0;
      if ($urandom % 7 == 0) pinIn = 16'($urandom);
      if (inReady && ($urandom % 3) != 0) begin
        inValid = 1'b1;
        inData  = ($urandom % 4 == 0) ? 8'($urandom) : (8'h80 | 8'($urandom % 4));
      end else begin
        inValid = 1'b0;
      end
    end
    @(negedge clk);
    inValid  = 1'b0;
    outReady = 1'b1;
    repeat (10) @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule